// File: doc/BRIEF.md
# Stream-to-memory descriptor walker

This block takes inbound stream packets and scatters them into memory buffers described by a linked chain of descriptors. Software builds the chain and loads the current pointer. It then writes the tail pointer, which wakes the walker. The walker reads a descriptor and fills its buffer with incoming stream words until the buffer is full or the packet ends. It then writes a status word back into the descriptor and follows the next pointer. A packet longer than one buffer spills into the following descriptors. The descriptor that takes the last beat also receives the packet's sideband words.

All memory traffic uses a single 32-bit word port with a request/ready handshake. The stream input is held off while descriptor reads and write-backs are in flight. The walker stops and raises idle when it finishes the tail descriptor, or when it reads a descriptor that is already marked complete. If it runs out of descriptors partway through a packet, it accepts and discards the rest of that packet so the stream never locks up. A one-cycle pulse reports each packet that landed completely.

Top module: `s2m_desc_walker`

## Requirements
- R1: After reset, idle is high, the current pointer is 0, stream ready is low, and neither a memory request nor a completion pulse is driven.
- R2: Descriptor reads start only while run is high and idle is low. A tail write clears idle on the next cycle, and it wins over an idle set in the same cycle. While idle or not running, with no discard in progress, stream ready stays low and no memory request is made.
- R3: A descriptor is 32-bit words at byte offsets from its base: next pointer at 0, buffer address at 4, control at 12, status at 16, sideband words at 20 + 4·i. Control bits 22:0 give the capacity in bytes, rounded down to whole 4-byte words. If the fetched status has bit 31 set, idle is set, the current pointer is unchanged and nothing is written.
- R4: Stream words go to consecutive words of the buffer, starting at its address. A descriptor takes the smaller of its capacity and the words left in the packet. The rest of the packet continues in the next descriptor, and buffer words beyond the count are not written.
- R5: Each used descriptor gets a status write-back with the following fields:
  - bit 31 is set;
  - bits 22:0 hold the bytes written (4 per word);
  - bit 27 is set only on the first descriptor of a packet;
  - bit 26 is set only on the descriptor that took the last beat;
  - all other bits are zero.
- R6: The APPN sideband words, captured with the last beat, are written at offsets 20 onward of the descriptor that ends the packet. No other descriptor has its sideband words written.
- R7: The completion output pulses for one cycle, the cycle after the status write of a packet's final descriptor. A packet cut short by running out of descriptors gives no pulse.
- R8: After each status write-back, the current pointer takes the descriptor's next pointer. If the finished descriptor's address equals the tail, idle is set.
- R9: If idle is set partway through a packet, stream ready stays high and the remaining beats are dropped up to and including the last one. The next packet accepted after a tail write starts with bit 27 set.
- R10: Stream ready is low in every cycle with a memory request. A request that is not yet granted keeps its address, direction and write data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_run | input | 1 | Run enable level |
| cfg_cur_wr | input | 1 | Load pulse for the current pointer |
| cfg_cur_val | input | AW | Value loaded into the current pointer |
| cfg_tail_wr | input | 1 | Tail write pulse; clears idle |
| cfg_tail | input | AW | Tail descriptor address |
| stat_cur | output | AW | Current descriptor pointer |
| stat_idle | output | 1 | Idle flag |
| s_valid | input | 1 | Stream beat valid |
| s_ready | output | 1 | Stream beat accepted |
| s_data | input | 32 | Stream word |
| s_last | input | 1 | Last beat of packet |
| s_app | input | 32*APPN | Sideband words, sampled with the last beat |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request granted this cycle |
| mem_rdata | input | 32 | Read data, valid when a read is granted |
| pkt_done | output | 1 | Packet completion pulse |

## Verification
The bench builds the block with its defaults: 32-bit pointers, a 23-bit length field and five sideband words. It attaches a 1 KB word memory that can stall grants in a pseudo-random pattern. Buffer capacities of 1 to 3 words are swept against packet lengths of 1 to 7 words, with and without stalls, and with junk in the sub-word capacity bits. This covers every split of a packet over up to seven descriptors, and exact fits as well as partial ones. Short dedicated chains cover tail exhaustion in mid-packet with discard and restart, a descriptor that is already complete, and a run level held low.

// File: rtl/s2mw_pkg.sv
package s2mw_pkg;
   localparam int WORD_W = 32;
   localparam int WORD_B = WORD_W / 8;
   localparam int BSH    = $clog2(WORD_B);

   // Descriptor field byte offsets
   localparam int OFS_NEXT = 0;
   localparam int OFS_BUF  = 4;
   localparam int OFS_CTRL = 12;
   localparam int OFS_STAT = 16;
   localparam int OFS_APP  = 20;

   // Status bit positions
   localparam int ST_DONE_BIT = 31;
   localparam int ST_SOP_BIT  = 27;
   localparam int ST_EOP_BIT  = 26;

   typedef enum logic [2:0] {
      W_WAIT, W_FETCH, W_DATA, W_WRITE, W_APPW, W_STAT, W_DROP
   } wstate_t;
endpackage

// File: rtl/s2mw_ptr_regs.sv
module s2mw_ptr_regs #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cur_wr,
   input  logic [AW-1:0] cur_val,
   input  logic          tail_wr,
   input  logic [AW-1:0] tail_val,
   input  logic          advance,
   input  logic [AW-1:0] next_ptr,
   input  logic          stop_req,
   output logic [AW-1:0] cur,
   output logic          idle,
   output logic          at_tail
);
   assign at_tail = (cur == tail_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur  <= '0;
         idle <= 1'b1;
      end else begin
         if (cur_wr)       cur <= cur_val;
         else if (advance) cur <= next_ptr;
         if (tail_wr)       idle <= 1'b0;
         else if (stop_req) idle <= 1'b1;
      end
   end
endmodule

// File: rtl/s2mw_status_fmt.sv
module s2mw_status_fmt
   import s2mw_pkg::*;
#(
   parameter int LENW = 23
) (
   input  logic [LENW-1:0]   nbytes,
   input  logic              sop,
   input  logic              eop,
   output logic [WORD_W-1:0] word
);
   always_comb begin
      word              = '0;
      word[LENW-1:0]    = nbytes;
      word[ST_SOP_BIT]  = sop;
      word[ST_EOP_BIT]  = eop;
      word[ST_DONE_BIT] = 1'b1;
   end
endmodule

// File: rtl/s2mw_app_latch.sv
module s2mw_app_latch
   import s2mw_pkg::*;
#(
   parameter int N   = 5,
   parameter int SEL = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cap_en,
   input  logic [N*WORD_W-1:0] app_in,
   input  logic [SEL-1:0]      sel,
   output logic [WORD_W-1:0]   word_out
);
   logic [WORD_W-1:0] bank [N];

   for (genvar i = 0; i < N; i++) begin : g_word
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      q <= '0;
         else if (cap_en) q <= app_in[i*WORD_W +: WORD_W];
      end
      assign bank[i] = q;
   end

   assign word_out = bank[sel];
endmodule

// File: rtl/s2m_desc_walker.sv
module s2m_desc_walker
   import s2mw_pkg::*;
#(
   parameter int AW   = 32,
   parameter int LENW = 23,
   parameter int APPN = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_run,
   input  logic                   cfg_cur_wr,
   input  logic [AW-1:0]          cfg_cur_val,
   input  logic                   cfg_tail_wr,
   input  logic [AW-1:0]          cfg_tail,
   output logic [AW-1:0]          stat_cur,
   output logic                   stat_idle,
   input  logic                   s_valid,
   output logic                   s_ready,
   input  logic [WORD_W-1:0]      s_data,
   input  logic                   s_last,
   input  logic [APPN*WORD_W-1:0] s_app,
   output logic                   mem_req,
   output logic                   mem_we,
   output logic [AW-1:0]          mem_addr,
   output logic [WORD_W-1:0]      mem_wdata,
   input  logic                   mem_ready,
   input  logic [WORD_W-1:0]      mem_rdata,
   output logic                   pkt_done
);
   localparam int CW  = LENW - BSH;
   localparam int AIW = (APPN > 1) ? $clog2(APPN) : 1;

   if (AW <= LENW || AW > WORD_W) begin : g_bad_aw
      $error("AW must exceed LENW and fit one memory word");
   end
   if (LENW <= BSH || LENW > ST_EOP_BIT) begin : g_bad_lenw
      $error("LENW must leave the status flag bits free");
   end
   if (APPN < 1 || APPN > 6) begin : g_bad_appn
      $error("APPN must be between 1 and 6");
   end

   wstate_t           st;
   logic [1:0]        fidx;
   logic [AW-1:0]     nxt_q, buf_q, fofs;
   logic [CW-1:0]     cap_q, cnt_q;
   logic [WORD_W-1:0] dat_q, app_word, stat_word;
   logic              last_q, eop_q, sop_q, inpkt_q, done_q;
   logic [AIW-1:0]    aidx_q;
   logic              at_tail, advance, stop_req, grant, cap_en;
   logic              unused_rd;

   assign unused_rd = ^{mem_rdata[ST_DONE_BIT-1:LENW]};
   assign grant     = mem_req && mem_ready;
   assign advance   = (st == W_STAT) && mem_ready;
   assign stop_req  = ((st == W_FETCH) && mem_ready && (fidx == 2'd3) && mem_rdata[ST_DONE_BIT])
                    || (advance && at_tail);
   assign cap_en    = (st == W_DATA) && s_valid && s_last;
   assign s_ready   = (st == W_DATA) || (st == W_DROP);
   assign pkt_done  = done_q;

   s2mw_ptr_regs #(.AW(AW)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .cur_wr(cfg_cur_wr), .cur_val(cfg_cur_val),
      .tail_wr(cfg_tail_wr), .tail_val(cfg_tail),
      .advance(advance), .next_ptr(nxt_q), .stop_req(stop_req),
      .cur(stat_cur), .idle(stat_idle), .at_tail(at_tail)
   );

   s2mw_status_fmt #(.LENW(LENW)) u_fmt (
      .nbytes({cnt_q, {BSH{1'b0}}}), .sop(sop_q), .eop(eop_q), .word(stat_word)
   );

   s2mw_app_latch #(.N(APPN), .SEL(AIW)) u_app (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .app_in(s_app),
      .sel(aidx_q), .word_out(app_word)
   );

   always_comb begin
      case (fidx)
         2'd0:    fofs = AW'(OFS_NEXT);
         2'd1:    fofs = AW'(OFS_BUF);
         2'd2:    fofs = AW'(OFS_CTRL);
         default: fofs = AW'(OFS_STAT);
      endcase
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = stat_cur;
      mem_wdata = '0;
      case (st)
         W_FETCH: begin
            mem_req  = 1'b1;
            mem_addr = stat_cur + fofs;
         end
         W_WRITE: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = buf_q + AW'({cnt_q, {BSH{1'b0}}});
            mem_wdata = dat_q;
         end
         W_APPW: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = stat_cur + AW'(OFS_APP) + AW'({aidx_q, {BSH{1'b0}}});
            mem_wdata = app_word;
         end
         W_STAT: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = stat_cur + AW'(OFS_STAT);
            mem_wdata = stat_word;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= W_WAIT;
         fidx    <= '0;
         nxt_q   <= '0;
         buf_q   <= '0;
         cap_q   <= '0;
         cnt_q   <= '0;
         dat_q   <= '0;
         last_q  <= 1'b0;
         eop_q   <= 1'b0;
         sop_q   <= 1'b1;
         inpkt_q <= 1'b0;
         aidx_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st)
            W_WAIT: if (cfg_run && !stat_idle) begin
               st   <= W_FETCH;
               fidx <= '0;
            end
            W_FETCH: if (grant) begin
               fidx <= fidx + 1'b1;
               case (fidx)
                  2'd0: nxt_q <= mem_rdata[AW-1:0];
                  2'd1: buf_q <= mem_rdata[AW-1:0];
                  2'd2: cap_q <= mem_rdata[LENW-1:BSH];
                  default: begin
                     cnt_q <= '0;
                     eop_q <= 1'b0;
                     if (mem_rdata[ST_DONE_BIT]) st <= inpkt_q ? W_DROP : W_WAIT;
                     else if (cap_q == '0)       st <= W_STAT;
                     else                        st <= W_DATA;
                  end
               endcase
            end
            W_DATA: if (s_valid) begin
               dat_q   <= s_data;
               last_q  <= s_last;
               inpkt_q <= !s_last;
               st      <= W_WRITE;
            end
            W_WRITE: if (grant) begin
               cnt_q <= cnt_q + 1'b1;
               if (last_q) begin
                  eop_q  <= 1'b1;
                  aidx_q <= '0;
                  st     <= W_APPW;
               end else if (cnt_q + 1'b1 == cap_q) begin
                  st <= W_STAT;
               end else begin
                  st <= W_DATA;
               end
            end
            W_APPW: if (grant) begin
               if (aidx_q == AIW'(APPN - 1)) st <= W_STAT;
               else                          aidx_q <= aidx_q + 1'b1;
            end
            W_STAT: if (grant) begin
               done_q <= eop_q;
               sop_q  <= eop_q || (sop_q && !inpkt_q);
               st     <= (at_tail && inpkt_q) ? W_DROP : W_WAIT;
            end
            W_DROP: if (s_valid && s_last) begin
               inpkt_q <= 1'b0;
               sop_q   <= 1'b1;
               st      <= W_WAIT;
            end
            default: st <= W_WAIT;
         endcase
      end
   end
endmodule

// File: rtl/s2mw_checker.sv
module s2mw_checker #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_cur_wr,
   input logic          cfg_tail_wr,
   input logic          stat_idle,
   input logic          s_ready,
   input logic          mem_req,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [31:0]   mem_wdata,
   input logic          mem_ready,
   input logic          pkt_done
);
   AST_NO_INTAKE_DURING_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !s_ready); // R10

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready && !cfg_cur_wr) |=>
         (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R10

   AST_TAIL_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_tail_wr |=> !stat_idle); // R2

   AST_READ_ONLY_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> !stat_idle); // R2

   AST_DONE_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_done |-> $past(mem_req && mem_we && mem_ready && mem_wdata[31] && mem_wdata[26])); // R7
endmodule

bind s2m_desc_walker s2mw_checker #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_cur_wr(cfg_cur_wr), .cfg_tail_wr(cfg_tail_wr),
   .stat_idle(stat_idle), .s_ready(s_ready), .mem_req(mem_req), .mem_we(mem_we),
   .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready), .pkt_done(pkt_done)
);

// File: tb/sim_s2m_desc_walker.sv
module sim_s2m_desc_walker;
   localparam int AW = 32, LENW = 23, APPN = 5;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n, cfg_run, cfg_cur_wr, cfg_tail_wr;
   logic [AW-1:0] cfg_cur_val, cfg_tail, stat_cur;
   logic stat_idle, s_valid, s_ready, s_last;
   logic [31:0] s_data;
   logic [APPN*32-1:0] s_app;
   logic mem_req, mem_we, mem_ready, pkt_done;
   logic [AW-1:0] mem_addr;
   logic [31:0] mem_wdata, mem_rdata;

   s2m_desc_walker #(.AW(AW), .LENW(LENW), .APPN(APPN)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_run(cfg_run), .cfg_cur_wr(cfg_cur_wr),
      .cfg_cur_val(cfg_cur_val), .cfg_tail_wr(cfg_tail_wr), .cfg_tail(cfg_tail),
      .stat_cur(stat_cur), .stat_idle(stat_idle), .s_valid(s_valid), .s_ready(s_ready),
      .s_data(s_data), .s_last(s_last), .s_app(s_app), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
      .mem_rdata(mem_rdata), .pkt_done(pkt_done)
   );

   logic [31:0] mem [0:255];
   logic [7:0]  lfsr = 8'hA7;
   logic        stall_en = 1'b0;
   int npkt = 0, nreq = 0, cyc = 0, total = 0, bad = 0;

   assign mem_ready = !stall_en || lfsr[0];
   assign mem_rdata = mem[mem_addr[9:2]];

   always @(posedge clk) begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (mem_req && mem_we && mem_ready) mem[mem_addr[9:2]] <= mem_wdata;
      if (pkt_done) npkt <= npkt + 1;
      if (mem_req)  nreq <= nreq + 1;
      cyc <= cyc + 1;
      if (cyc == 190000) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   function automatic logic [31:0] dA(input int i); return 32'(i * 48); endfunction
   function automatic logic [31:0] bA(input int i); return 32'h200 + 32'(i * 32); endfunction
   function automatic logic [31:0] dword(input int tag, input int k);
      return {16'(tag), 8'h5A, 8'(k)};
   endfunction
   function automatic logic [31:0] aword(input int tag, input int i);
      return {8'hC0, 8'(i), 16'(tag)};
   endfunction
   function automatic logic [31:0] xstat(input int w, input bit sop, input bit eop);
      return 32'(w * 4) | 32'h8000_0000 | (32'(sop) << 27) | (32'(eop) << 26);
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; cfg_run = 0; cfg_cur_wr = 0; cfg_tail_wr = 0;
      cfg_cur_val = '0; cfg_tail = '0; s_valid = 0; s_last = 0; s_data = '0; s_app = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic build(input int n, input logic [31:0] cb);
      for (int a = 0; a < 256; a++) mem[a] = '0;
      for (int i = 0; i < n; i++) begin
         mem[dA(i) >> 2]       = dA((i + 1) % n);
         mem[(dA(i) >> 2) + 1] = bA(i);
         mem[(dA(i) >> 2) + 3] = cb;
      end
   endtask

   task automatic setup(input int tail_i, input bit run);
      cfg_cur_val = dA(0); cfg_cur_wr = 1; cfg_tail = dA(tail_i); cfg_tail_wr = 1; cfg_run = run;
      @(negedge clk);
      cfg_cur_wr = 0; cfg_tail_wr = 0;
   endtask

   task automatic send(input int tag, input int len, output bit ok);
      int g;
      ok = 1;
      for (int i = 0; i < APPN; i++) s_app[i*32 +: 32] = aword(tag, i);
      for (int k = 0; k < len; k++) begin
         s_valid = 1; s_data = dword(tag, k); s_last = (k == len - 1);
         g = 0;
         while (!s_ready && g < 3000) begin @(negedge clk); g++; end
         if (g >= 3000) ok = 0;
         @(negedge clk);
      end
      s_valid = 0; s_last = 0;
   endtask

   task automatic wait_pkt(input int target);
      int g = 0;
      while (npkt < target && g < 3000) begin @(negedge clk); g++; end
      repeat (2) @(negedge clk);
   endtask

   initial begin
      bit ok;
      int p0, r0, seen;
      do_reset();
      chk("R1", "idle after reset", 32'(stat_idle), 32'd1);
      chk("R1", "cur after reset", stat_cur, 32'd0);
      chk("R1", "ready after reset", 32'(s_ready), 32'd0);
      chk("R1", "req after reset", 32'(mem_req), 32'd0);
      chk("R1", "done after reset", 32'(pkt_done), 32'd0);
      r0 = nreq; cfg_run = 1;
      repeat (20) @(negedge clk);
      chk("R2", "no fetch while idle", 32'(nreq - r0), 32'd0);

      // R4 R5 R6 R7 R8 sweep of capacity against packet length
      for (int pass = 0; pass < 2; pass++)
         for (int cap = 1; cap <= 3; cap++)
            for (int len = 1; len <= 7; len++) begin
               int tag, nd;
               tag = pass * 100 + cap * 10 + len;
               nd = (len + cap - 1) / cap;
               stall_en = 0;
               do_reset();
               build(8, 32'(cap * 4 + (pass ? 3 : 0)));
               stall_en = pass[0];
               setup(7, 1);
               p0 = npkt;
               send(tag, len, ok);
               wait_pkt(p0 + 1);
               for (int j = 0; j < nd; j++) begin
                  int w;
                  w = (len - j * cap < cap) ? len - j * cap : cap;
                  chk("R5", "status", mem[(dA(j) >> 2) + 4], xstat(w, j == 0, j == nd - 1));
                  for (int m = 0; m < w; m++)
                     chk("R4", "buffer word", mem[(bA(j) >> 2) + m], dword(tag, j * cap + m));
                  chk("R4", "word past count", mem[(bA(j) >> 2) + w], 32'd0);
                  chk("R3", "control kept", mem[(dA(j) >> 2) + 3], 32'(cap * 4 + (pass ? 3 : 0)));
                  for (int i = 0; i < APPN; i++)
                     chk("R6", "sideband", mem[(dA(j) >> 2) + 5 + i],
                         (j == nd - 1) ? aword(tag, i) : 32'd0);
               end
               chk("R8", "next desc untouched", mem[(dA(nd) >> 2) + 4], 32'd0);
               chk("R8", "cur advanced", stat_cur, dA(nd));
               chk("R8", "not idle", 32'(stat_idle), 32'd0);
               chk("R7", "one pulse", 32'(npkt - p0), 32'd1);
            end
      stall_en = 0;

      // R9 discard after tail reached mid-packet, then restart
      do_reset();
      build(3, 32'd8);
      setup(1, 1);
      p0 = npkt;
      send(900, 6, ok);
      repeat (10) @(negedge clk);
      chk("R9", "all beats taken", 32'(ok), 32'd1);
      chk("R9", "dropped beat", mem[bA(2) >> 2], 32'd0);
      chk("R8", "idle at tail", 32'(stat_idle), 32'd1);
      chk("R8", "cur past tail", stat_cur, dA(2));
      chk("R7", "no pulse truncated", 32'(npkt - p0), 32'd0);
      chk("R5", "first desc", mem[(dA(0) >> 2) + 4], xstat(2, 1, 0));
      chk("R5", "middle desc", mem[(dA(1) >> 2) + 4], xstat(2, 0, 0));
      chk("R2", "ready low when idle", 32'(s_ready), 32'd0);
      cfg_tail = dA(2); cfg_tail_wr = 1;
      @(negedge clk);
      cfg_tail_wr = 0;
      send(901, 1, ok);
      wait_pkt(p0 + 1);
      chk("R9", "sop after discard", mem[(dA(2) >> 2) + 4], xstat(1, 1, 1));
      chk("R4", "resumed data", mem[bA(2) >> 2], dword(901, 0));
      chk("R8", "wrap to first", stat_cur, dA(0));
      chk("R8", "idle again", 32'(stat_idle), 32'd1);

      // R3 descriptor already complete
      do_reset();
      build(4, 32'd4);
      mem[(dA(0) >> 2) + 4] = 32'h8000_0004;
      setup(3, 1);
      repeat (20) @(negedge clk);
      chk("R3", "idle on complete", 32'(stat_idle), 32'd1);
      chk("R3", "cur kept", stat_cur, dA(0));
      chk("R3", "status kept", mem[(dA(0) >> 2) + 4], 32'h8000_0004);
      seen = 0;
      s_valid = 1; s_data = 32'hFFFF_FFFF; s_last = 1;
      for (int t = 0; t < 10; t++) begin
         if (s_ready) seen++;
         @(negedge clk);
      end
      s_valid = 0; s_last = 0;
      chk("R2", "stream held while idle", 32'(seen), 32'd0);

      // R2 run low holds the walker
      do_reset();
      build(4, 32'd8);
      r0 = nreq;
      setup(3, 0);
      chk("R2", "tail write clears idle", 32'(stat_idle), 32'd0);
      repeat (30) @(negedge clk);
      chk("R2", "no request without run", 32'(nreq - r0), 32'd0);
      chk("R2", "no ready without run", 32'(s_ready), 32'd0);
      cfg_run = 1;
      p0 = npkt;
      send(777, 3, ok);
      wait_pkt(p0 + 1);
      chk("R5", "run resumed first", mem[(dA(0) >> 2) + 4], xstat(2, 1, 0));
      chk("R5", "run resumed last", mem[(dA(1) >> 2) + 4], xstat(1, 0, 1));
      chk("R4", "run resumed data", mem[(bA(1) >> 2)], dword(777, 2));

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule